// File: doc/BRIEF.md
# Self-Starting Five-State Counter with Seven-Segment Output

This block is a 3-bit synchronous counter that runs through a fixed, non-binary loop of five values: 1, 3, 4, 6, 7, and then back to 1. All state bits sit in D-type registers that share one clock. Each bit's next value comes straight from the present state, so every update settles one register delay after the edge.

The codes 0, 2 and 5 are not part of the loop. Each has a defined successor that re-enters the loop on the next clock. Whatever value the register holds at power-up, the counter therefore starts itself without outside help. The power-up value is modelled by the `RESET_STATE` parameter.

The present state also drives a BCD-to-seven-segment decoder, with the top decoder bit tied to 0, so the display shows the count as a decimal digit. The `ACTIVE_LOW` parameter selects the segment polarity. Set it to 0 for common-cathode parts, where a lit segment is 1. Set it to 1 for common-anode parts, where a lit segment is 0.

Top module: `seqdisp_top`

## Requirements
- R1: While `en` is 1 and `rst` is 0, each rising clock edge moves `state` from 1 to 3, from 3 to 4, from 4 to 6, from 6 to 7, and from 7 back to 1.
- R2: A rising edge with `rst` at 1 loads `state` with `RESET_STATE` (default 1). This is a synchronous reset.
- R3: From an unused code, one enabled edge leads back into the loop: 0 goes to 1, 2 goes to 3, and 5 goes to 6.
- R4: While `en` is 0 and `rst` is 0, `state` keeps its value across clock edges.
- R5: `seg` shows the decimal digit equal to `state` in the bit order {a,b,c,d,e,f,g}, with a as bit 6. The lit-segment patterns are 0=1111110, 1=0110000, 2=1101101, 3=1111001, 4=0110011, 5=1011011, 6=1011111 and 7=1110000. With `ACTIVE_LOW`=1 every bit of the pattern is inverted. Decoder inputs 10 to 15 light no segment.
- R6: `rst` takes priority over `en`: a reset edge loads `RESET_STATE` whatever the value of `en`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by all state bits |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Count enable, active high |
| state | output | 3 | Present counter state |
| seg | output | 7 | Segment lines {a,b,c,d,e,f,g}, polarity set by `ACTIVE_LOW` |

## Verification
The bench targets the three unused codes. It builds copies of the counter that reset into 0, 2 and 5, and checks that a single enabled edge lands each one on 1, 3 and 6. A next-state map that missed one of these codes would either stay trapped outside the loop or enter it at the wrong point. The wrap from 7 to 1 is also checked, since a design that got it wrong would fall into 0 or count in plain binary. Enable-low holds and reset with enable high are checked as well: a wrong design would drift while disabled or ignore the reset. Segment patterns are compared for both polarities, which catches a reversed bit order or a missing inversion.

// File: rtl/seqdisp_pkg.sv
package seqdisp_pkg;
    localparam int CNT_W = 3;
    localparam int DIG_W = 4;
    localparam int SEG_W = 7;

    typedef logic [CNT_W-1:0] cnt_t;
    typedef logic [DIG_W-1:0] dig_t;
    typedef logic [SEG_W-1:0] seg_t;

    typedef struct packed {
        cnt_t state;
    } regs_t;
endpackage

// File: rtl/seq_next.sv
module seq_next
    import seqdisp_pkg::*;
(
    input  cnt_t cur,
    output cnt_t nxt
);
    always_comb begin
        unique case (cur)
            3'd0:    nxt = 3'd1;  // stray code rejoins at 1
            3'd1:    nxt = 3'd3;
            3'd2:    nxt = 3'd3;  // stray code rejoins at 3
            3'd3:    nxt = 3'd4;
            3'd4:    nxt = 3'd6;
            3'd5:    nxt = 3'd6;  // stray code rejoins at 6
            3'd6:    nxt = 3'd7;
            default: nxt = 3'd1;  // 7 wraps to 1
        endcase
    end
endmodule

// File: rtl/seg_decode.sv
module seg_decode
    import seqdisp_pkg::*;
#(
    parameter bit ACTIVE_LOW = 1'b0
) (
    input  dig_t digit,
    output seg_t seg
);
    seg_t lit;

    always_comb begin
        case (digit)
            4'd0:    lit = 7'b1111110;
            4'd1:    lit = 7'b0110000;
            4'd2:    lit = 7'b1101101;
            4'd3:    lit = 7'b1111001;
            4'd4:    lit = 7'b0110011;
            4'd5:    lit = 7'b1011011;
            4'd6:    lit = 7'b1011111;
            4'd7:    lit = 7'b1110000;
            4'd8:    lit = 7'b1111111;
            4'd9:    lit = 7'b1111011;
            default: lit = 7'b0000000;  // 10..15 blank
        endcase
    end

    // R5: every valid digit lights at least two segments, no invalid one lights any
    always_comb begin
        if (digit <= 4'd9) begin
            p_digit_lit_r5: assert ($countones(lit) >= 2);
        end else begin
            p_blank_r5: assert (lit == '0);
        end
    end

    generate
        if (ACTIVE_LOW) begin : g_anode
            assign seg = ~lit;
        end else begin : g_cathode
            assign seg = lit;
        end
    endgenerate
endmodule

// File: rtl/seqdisp_top.sv
module seqdisp_top
    import seqdisp_pkg::*;
#(
    parameter bit ACTIVE_LOW  = 1'b0,
    parameter int RESET_STATE = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    output logic [CNT_W-1:0] state,
    output logic [SEG_W-1:0] seg
);
    localparam cnt_t INIT_VAL = cnt_t'(RESET_STATE);

    regs_t r_d, r_q;
    cnt_t  step_d;
    dig_t  digit_d;

    seq_next u_next (
        .cur (r_q.state),
        .nxt (step_d)
    );

    always_comb begin
        r_d = r_q;
        if (rst) begin
            r_d.state = INIT_VAL;
        end else if (en) begin
            r_d.state = step_d;
        end
    end

    always_ff @(posedge clk) begin
        r_q <= r_d;
    end

    assign state   = r_q.state;
    assign digit_d = {1'b0, r_q.state};

    seg_decode #(.ACTIVE_LOW(ACTIVE_LOW)) u_dec (
        .digit (digit_d),
        .seg   (seg)
    );

    p_reset_load_r2: assert property (@(posedge clk)
        rst |=> state == INIT_VAL);

    p_reset_wins_r6: assert property (@(posedge clk)
        (rst && en) |=> state == INIT_VAL);

    p_wrap_r1: assert property (@(posedge clk) disable iff (rst)
        (en && state == 3'd7) |=> state == 3'd1);

    p_loop_only_r3: assert property (@(posedge clk) disable iff (rst)
        en |=> (state != 3'd0 && state != 3'd2 && state != 3'd5));

    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !en |=> state == $past(state));
endmodule

// File: tb/sim_seqdisp_top.sv
module sim_seqdisp_top;
    localparam int PERIOD = 10;
    localparam int NI = 4;
    localparam int INITS[NI] = '{1, 0, 2, 5};
    localparam bit LOWS[NI]  = '{1'b0, 1'b1, 1'b1, 1'b0};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en  = 1'b0;
    logic [2:0] st [NI];
    logic [6:0] sg [NI];
    int mdl [NI];
    int checks = 0;
    int errors = 0;

    always #(PERIOD/2) clk = ~clk;

    seqdisp_top #(.ACTIVE_LOW(1'b0), .RESET_STATE(1)) u0 (.clk(clk), .rst(rst), .en(en), .state(st[0]), .seg(sg[0]));
    seqdisp_top #(.ACTIVE_LOW(1'b1), .RESET_STATE(0)) u1 (.clk(clk), .rst(rst), .en(en), .state(st[1]), .seg(sg[1]));
    seqdisp_top #(.ACTIVE_LOW(1'b1), .RESET_STATE(2)) u2 (.clk(clk), .rst(rst), .en(en), .state(st[2]), .seg(sg[2]));
    seqdisp_top #(.ACTIVE_LOW(1'b0), .RESET_STATE(5)) u3 (.clk(clk), .rst(rst), .en(en), .state(st[3]), .seg(sg[3]));

    function automatic int succ(int v);
        int loop_q[$] = '{1, 3, 4, 6, 7};
        for (int k = 0; k < loop_q.size(); k++)
            if (loop_q[k] == v) return loop_q[(k + 1) % loop_q.size()];
        return v + 1;  // unused codes step onto the next loop value
    endfunction

    function automatic logic [6:0] glyph(int v, bit low);
        logic [6:0] p;
        case (v)
            0: p = 7'h7E; 1: p = 7'h30; 2: p = 7'h6D; 3: p = 7'h79;
            4: p = 7'h33; 5: p = 7'h5B; 6: p = 7'h5F; 7: p = 7'h70;
            default: p = 7'h00;
        endcase
        return low ? ~p : p;
    endfunction

    always @(posedge clk) begin
        for (int i = 0; i < NI; i++) begin
            if (rst) mdl[i] <= INITS[i];
            else if (en) mdl[i] <= succ(mdl[i]);
        end
    end

    task automatic check_all(string tag);
        for (int i = 0; i < NI; i++) begin
            checks++;
            if (int'(st[i]) != mdl[i]) begin
                errors++;
                $display("FAIL %s u%0d state actual=%0d expected=%0d", tag, i, st[i], mdl[i]);
            end
            checks++;
            if (sg[i] !== glyph(mdl[i], LOWS[i])) begin
                errors++;
                $display("FAIL R5 u%0d seg actual=%b expected=%b", i, sg[i], glyph(mdl[i], LOWS[i]));
            end
        end
    endtask

    task automatic run(bit r, bit e, int n, string tag);
        rst = r;
        en  = e;
        for (int c = 0; c < n; c++) begin
            @(negedge clk);
            check_all(tag);
        end
    endtask

    initial begin
        run(1'b1, 1'b0, 2, "R2");   // reset state, all power-up codes
        run(1'b0, 1'b1, 1, "R3");   // 0->1, 2->3, 5->6 in one edge
        run(1'b0, 1'b1, 12, "R1");  // full loop twice, wrap 7->1
        run(1'b0, 1'b0, 3, "R4");   // hold with enable low
        for (int k = 0; k < 4; k++) begin
            run(1'b0, 1'b1, 1, "R1");
            run(1'b0, 1'b0, 1, "R4");
        end
        run(1'b1, 1'b1, 1, "R6");   // reset beats enable
        run(1'b0, 1'b1, 1, "R3");
        run(1'b0, 1'b1, 6, "R1");
        run(1'b1, 1'b0, 1, "R2");
        run(1'b0, 1'b0, 2, "R4");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(PERIOD * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule